// File: doc/BRIEF.md
# Timestamp Exchange Slave Controller

This block is the follower half of a two-node, four-timestamp time transfer scheme. It watches a stream of already decoded frames. A SYNC frame starts an exchange and the block records its own local time as the arrival stamp t2. A FOLLOW_UP frame then delivers the leader's departure stamp t1. A prompt frame tells the block to send its own delay request, and the block records the local time of that departure as t3. A DELAY_RESP frame returns the leader's arrival stamp t4.

After the exchange, the block asks an external phase measurement unit for the clock phase lag between the two nodes. It moves t4 earlier by that lag and computes the clock offset, assuming the path delay is the same in both directions. It then applies the correction to its own local time counter in one cycle.

Every state that waits for an outside event gives up after a parameterised number of cycles and returns to idle. A phase measurement that reports an error also sends the block back to idle, and the local clock is left unchanged.

Top module: `tss_slave_ctrl`

## Requirements
- R1: While rst_n is low, local_time is 0 and tx_req, ph_start and offset_load are 0. After reset, local_time rises by one every cycle unless a correction is loaded.
- R2: rx_type codes are 0 = SYNC, 1 = FOLLOW_UP, 2 = send-request prompt, 3 = DELAY_RESP. A SYNC frame seen in idle starts an exchange, and t2 is the value of local_time in the cycle that frame is presented.
- R3: In the wait-for-FOLLOW_UP state, a FOLLOW_UP frame supplies t1 through rx_payload. Frames of any other type are ignored, and a repeated SYNC does not replace t2.
- R4: In the cycle after a prompt frame is accepted, tx_req is high for exactly one cycle. t3 is the value of local_time during that cycle.
- R5: A DELAY_RESP frame that follows the request supplies t4 through rx_payload. ph_start then pulses high for one cycle in the next cycle.
- R6: When ph_ready is high and ph_error is low, the block takes ph_value as the phase lag and computes offset = ((t2 − t1) − ((t4 − ph_value) − t3)) >>> 1. The computation is exact on unsigned 64-bit operands, uses signed arithmetic that rounds toward minus infinity, and keeps the low 64 bits.
- R7: offset_load pulses for one cycle with the offset on offset_value. In the next cycle, local_time equals its value in the load cycle plus 1 minus the offset, modulo 2^64.
- R8: Each waiting state returns to idle once it has spent TIMEOUT cycles without its expected event. An expected event that arrives in the last of those cycles is still accepted.
- R9: In the phase-wait state, ph_error high (even together with ph_ready) returns the block to idle, and no correction is loaded.
- R10: In idle, frames other than SYNC are ignored: no request is sent and no exchange starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Decoded frame present this cycle |
| rx_type | input | 2 | Frame type code |
| rx_payload | input | TS_W | Timestamp carried by the frame |
| tx_req | output | 1 | One-cycle request to send a delay request frame |
| ph_start | output | 1 | One-cycle start for the phase measurement |
| ph_ready | input | 1 | Phase measurement finished |
| ph_error | input | 1 | Phase measurement failed |
| ph_value | input | TS_W | Measured phase lag in local time units |
| offset_load | output | 1 | One-cycle strobe that applies the offset |
| offset_value | output | TS_W | Computed clock offset, two's complement |
| local_time | output | TS_W | Local time counter |

## Verification
The bench builds the block with TIMEOUT = 8 and the default 64-bit timestamps. A short timeout puts both sides of the expiry boundary within a few cycles: a follow-up frame arriving in the eighth waiting cycle and another arriving in the ninth. It also lets the response-wait and phase-wait timeouts run out quickly. The timestamp table includes exchanges with negative offsets, positive offsets and odd differences, so the rounding of the halving step is exercised on both signs.

// File: rtl/tss_pkg.sv
// Shared definitions for the timestamp exchange slave controller.
// Assumes frame type codes are fixed by the upstream frame decoder.
package tss_pkg;
    localparam int TYPE_W = 2;
    localparam logic [TYPE_W-1:0] FT_SYNC   = 2'd0;
    localparam logic [TYPE_W-1:0] FT_FOLLOW = 2'd1;
    localparam logic [TYPE_W-1:0] FT_PROMPT = 2'd2;
    localparam logic [TYPE_W-1:0] FT_RESP   = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_FOL,
        ST_WAIT_PRE,
        ST_SEND_REQ,
        ST_WAIT_RESP,
        ST_PH_GO,
        ST_WAIT_PH,
        ST_CALC_GO,
        ST_WAIT_RES,
        ST_UPDATE
    } tss_state_e;
endpackage

// File: rtl/tss_tmo_counter.sv
// Cycle counter for state timeouts. It is cleared on every state change
// and flags expiry in the LIMIT-th cycle spent in the same state.
// Assumes LIMIT >= 2.
module tss_tmo_counter #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles in the current state, saturating at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LAST);

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> cnt_q == '0);
endmodule

// File: rtl/tss_offset_calc.sv
// Offset calculation: the arrival stamp is first moved earlier by the
// phase lag, and then half of the difference between the two path
// measurements is taken. Operands are unsigned and the arithmetic is
// widened so that it is exact. The result is registered one cycle
// after start_i.
module tss_offset_calc #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [TS_W-1:0] t1_i,
    input  logic [TS_W-1:0] t2_i,
    input  logic [TS_W-1:0] t3_i,
    input  logic [TS_W-1:0] t4_i,
    input  logic [TS_W-1:0] ph_i,
    output logic            done_o,
    output logic [TS_W-1:0] off_o
);
    localparam int XW = TS_W + 3;

    logic signed [XW-1:0] e1, e2, e3, e4, eph, fwd, back, diff;
    logic unused_bits;

    // Widened signed arithmetic for the two path differences.
    always_comb begin
        e1   = $signed({3'b000, t1_i});
        e2   = $signed({3'b000, t2_i});
        e3   = $signed({3'b000, t3_i});
        e4   = $signed({3'b000, t4_i});
        eph  = $signed({3'b000, ph_i});
        fwd  = e2 - e1;
        back = (e4 - eph) - e3;
        diff = fwd - back;
    end

    assign unused_bits = ^{diff[XW-1:TS_W+1], diff[0]};

    // Register the halved difference and its done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            off_o  <= '0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                off_o <= diff[TS_W:1];
            end
        end
    end
endmodule

// File: rtl/tss_local_clock.sv
// Local time counter. It advances by STEP each cycle. In a load cycle it
// advances by STEP and subtracts the offset at the same time.
module tss_local_clock #(
    parameter int TS_W = 64,
    parameter int STEP = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [TS_W-1:0] off_i,
    output logic [TS_W-1:0] time_o
);
    localparam logic [TS_W-1:0] INC = TS_W'(STEP);

    // Advance the time, folding in a correction when one is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_o <= '0;
        end else if (load_i) begin
            time_o <= time_o + INC - off_i;
        end else begin
            time_o <= time_o + INC;
        end
    end

    a_r1_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> time_o == $past(time_o) + INC);
    a_r7_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> time_o == $past(time_o) + INC - $past(off_i));
endmodule

// File: rtl/tss_slave_ctrl.sv
// Slave-side controller for the four-timestamp exchange. It sequences the
// frame waits, requests the delay frame, runs the phase handshake, starts
// the offset calculation and loads the correction into the local clock.
// Assumes at most one decoded frame per cycle and a phase unit that
// answers with ready or error.
module tss_slave_ctrl #(
    parameter int TS_W    = 64,
    parameter int TIMEOUT = 4096
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_valid,
    input  logic [tss_pkg::TYPE_W-1:0] rx_type,
    input  logic [TS_W-1:0]           rx_payload,
    output logic                      tx_req,
    output logic                      ph_start,
    input  logic                      ph_ready,
    input  logic                      ph_error,
    input  logic [TS_W-1:0]           ph_value,
    output logic                      offset_load,
    output logic [TS_W-1:0]           offset_value,
    output logic [TS_W-1:0]           local_time
);
    import tss_pkg::*;

    tss_state_e      state_q, state_d;
    logic [TS_W-1:0] t1_q, t2_q, t3_q, t4_q, ph_q;
    logic            expired, calc_start, calc_done;
    logic            got_sync, got_fol, got_pre, got_resp;

    assign got_sync = rx_valid && (rx_type == FT_SYNC);
    assign got_fol  = rx_valid && (rx_type == FT_FOLLOW);
    assign got_pre  = rx_valid && (rx_type == FT_PROMPT);
    assign got_resp = rx_valid && (rx_type == FT_RESP);

    // Next-state selection; an expected event takes priority over expiry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (got_sync) state_d = ST_WAIT_FOL;
            ST_WAIT_FOL:  if (got_fol) state_d = ST_WAIT_PRE;
                          else if (expired) state_d = ST_IDLE;
            ST_WAIT_PRE:  if (got_pre) state_d = ST_SEND_REQ;
                          else if (expired) state_d = ST_IDLE;
            ST_SEND_REQ:  state_d = ST_WAIT_RESP;
            ST_WAIT_RESP: if (got_resp) state_d = ST_PH_GO;
                          else if (expired) state_d = ST_IDLE;
            ST_PH_GO:     state_d = ST_WAIT_PH;
            ST_WAIT_PH:   if (ph_error) state_d = ST_IDLE;
                          else if (ph_ready) state_d = ST_CALC_GO;
                          else if (expired) state_d = ST_IDLE;
            ST_CALC_GO:   state_d = ST_WAIT_RES;
            ST_WAIT_RES:  if (calc_done) state_d = ST_UPDATE;
                          else if (expired) state_d = ST_IDLE;
            ST_UPDATE:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the timestamps and phase at the points the exchange defines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1_q <= '0; t2_q <= '0; t3_q <= '0; t4_q <= '0; ph_q <= '0;
        end else begin
            if (state_q == ST_IDLE && got_sync)     t2_q <= local_time;
            if (state_q == ST_WAIT_FOL && got_fol)  t1_q <= rx_payload;
            if (state_q == ST_SEND_REQ)             t3_q <= local_time;
            if (state_q == ST_WAIT_RESP && got_resp) t4_q <= rx_payload;
            if (state_q == ST_WAIT_PH && !ph_error && ph_ready) ph_q <= ph_value;
        end
    end

    assign tx_req      = (state_q == ST_SEND_REQ);
    assign ph_start    = (state_q == ST_PH_GO);
    assign calc_start  = (state_q == ST_CALC_GO);
    assign offset_load = (state_q == ST_UPDATE);

    tss_tmo_counter #(.LIMIT(TIMEOUT)) i_tmo (
        .clk(clk), .rst_n(rst_n),
        .clear_i(state_d != state_q),
        .expired_o(expired)
    );

    tss_offset_calc #(.TS_W(TS_W)) i_calc (
        .clk(clk), .rst_n(rst_n), .start_i(calc_start),
        .t1_i(t1_q), .t2_i(t2_q), .t3_i(t3_q), .t4_i(t4_q), .ph_i(ph_q),
        .done_o(calc_done), .off_o(offset_value)
    );

    tss_local_clock #(.TS_W(TS_W), .STEP(1)) i_clk (
        .clk(clk), .rst_n(rst_n), .load_i(offset_load),
        .off_i(offset_value), .time_o(local_time)
    );

    a_r2_t2_from_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && got_sync) |=> t2_q == $past(local_time));
    a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        ph_start |=> !ph_start);
    a_r6_done_leads_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RES && calc_done) |=> offset_load);
    a_r7_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        offset_load |=> !offset_load);
    a_r9_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_PH && ph_error) |=> state_q == ST_IDLE);
    a_r10_idle_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !got_sync) |=> state_q == ST_IDLE);
endmodule

// File: tb/test_tss_slave_ctrl.sv
`timescale 1ns/1ps
module test_tss_slave_ctrl;
    localparam int TS_W = 64;
    localparam int TMO  = 8;
    localparam int NV   = 6;
    // Each row: t1, t4, phase lag.
    localparam logic [63:0] VEC [NV][3] = '{
        '{64'd5000,    64'd5010,    64'd3},
        '{64'd20000,   64'd20031,   64'd0},
        '{64'd100,     64'd101,     64'd7},
        '{64'd1000000, 64'd1000050, 64'd12},
        '{64'd1000150, 64'd1000200, 64'd1},
        '{64'd1000300, 64'd1000351, 64'd4}
    };

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, ph_ready = 0, ph_error = 0;
    logic [1:0] rx_type = 0;
    logic [63:0] rx_payload = 0, ph_value = 0;
    logic tx_req, ph_start, offset_load;
    logic [63:0] offset_value, local_time;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    tss_slave_ctrl #(.TS_W(TS_W), .TIMEOUT(TMO)) i_tss_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_type(rx_type),
        .rx_payload(rx_payload), .tx_req(tx_req), .ph_start(ph_start),
        .ph_ready(ph_ready), .ph_error(ph_error), .ph_value(ph_value),
        .offset_load(offset_load), .offset_value(offset_value),
        .local_time(local_time)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one frame for one cycle; lt is local_time in that cycle.
    task automatic send(input logic [1:0] ty, input logic [63:0] pl, output logic [63:0] lt);
        rx_valid = 1; rx_type = ty; rx_payload = pl; lt = local_time;
        @(negedge clk);
        rx_valid = 0;
    endtask

    // Wait up to 20 cycles for an output strobe (0 tx_req, 1 ph_start, 2 offset_load).
    task automatic wait_sig(input int which, output bit seen, output logic [63:0] lt);
        seen = 0; lt = 0;
        for (int k = 0; k < 20; k++) begin
            if ((which == 0 && tx_req) || (which == 1 && ph_start) ||
                (which == 2 && offset_load)) begin
                seen = 1; lt = local_time;
                break;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic [63:0] exp_off(input logic [63:0] t1, t2, t3, t4, ph);
        logic signed [66:0] s;
        s = ($signed({3'b0, t2}) - $signed({3'b0, t1})) -
            (($signed({3'b0, t4}) - $signed({3'b0, ph})) - $signed({3'b0, t3}));
        return s[64:1];
    endfunction

    // One complete exchange with the offset and clock update checked.
    task automatic run_vec(input logic [63:0] t1, t4, ph, input bit dup_sync);
        logic [63:0] t2, t3, lt, dummy, e;
        bit seen;
        send(2'd0, 64'd0, t2);
        if (dup_sync) send(2'd0, 64'd77, dummy); // R3: repeated SYNC ignored
        send(2'd1, t1, dummy);
        send(2'd2, 64'd0, dummy);
        wait_sig(0, seen, t3);
        chk("R4 tx_req after prompt", 64'(seen), 64'd1);
        @(negedge clk);
        chk("R4 tx_req one cycle", 64'(tx_req), 64'd0);
        send(2'd3, t4, dummy);
        wait_sig(1, seen, lt);
        chk("R5 ph_start after resp", 64'(seen), 64'd1);
        @(negedge clk);
        ph_ready = 1; ph_value = ph;
        @(negedge clk);
        ph_ready = 0;
        wait_sig(2, seen, lt);
        chk("R7 offset_load seen", 64'(seen), 64'd1);
        e = exp_off(t1, t2, t3, t4, ph);
        chk("R6 offset value", offset_value, e);
        @(negedge clk);
        chk("R7 clock corrected", local_time, lt + 64'd1 - e);
        chk("R7 load one cycle", 64'(offset_load), 64'd0);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] lt, dummy;
        bit seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset time", local_time, 64'd0);
        chk("R1 reset strobes", {61'd0, tx_req, ph_start, offset_load}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        lt = local_time;
        @(negedge clk);
        chk("R1 free running", local_time, lt + 64'd1);

        // R2..R7: table of exchanges
        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);
            repeat (2) @(negedge clk);
        end

        // R3: repeated SYNC in follow wait keeps the first t2
        run_vec(64'd1000500, 64'd1000530, 64'd2, 1'b1);

        // R10: idle ignores non-SYNC frames
        send(2'd1, 64'd5, dummy);
        send(2'd2, 64'd0, dummy);
        wait_sig(0, seen, lt);
        chk("R10 no request from idle", 64'(seen), 64'd0);

        // R8: follow-up in the last waiting cycle is accepted
        send(2'd0, 64'd0, dummy);
        repeat (TMO - 1) @(negedge clk);
        send(2'd1, 64'd9, dummy);
        send(2'd2, 64'd0, dummy);
        wait_sig(0, seen, lt);
        chk("R8 accepted at boundary", 64'(seen), 64'd1);
        // R8: response wait times out, a late response is ignored
        repeat (TMO + 3) @(negedge clk);
        send(2'd3, 64'd9, dummy);
        wait_sig(1, seen, lt);
        chk("R8 response wait expired", 64'(seen), 64'd0);

        // R8: follow-up one cycle after the limit is rejected
        send(2'd0, 64'd0, dummy);
        repeat (TMO) @(negedge clk);
        send(2'd1, 64'd9, dummy);
        send(2'd2, 64'd0, dummy);
        wait_sig(0, seen, lt);
        chk("R8 rejected after limit", 64'(seen), 64'd0);

        // R9: phase error together with ready aborts the update
        send(2'd0, 64'd0, dummy);
        send(2'd1, 64'd50, dummy);
        send(2'd2, 64'd0, dummy);
        wait_sig(0, seen, lt);
        @(negedge clk);
        send(2'd3, 64'd60, dummy);
        wait_sig(1, seen, lt);
        @(negedge clk);
        ph_ready = 1; ph_error = 1; ph_value = 64'd5;
        lt = local_time;
        @(negedge clk);
        ph_ready = 0; ph_error = 0;
        wait_sig(2, seen, dummy);
        chk("R9 no load after error", 64'(seen), 64'd0);
        chk("R9 clock untouched", local_time, lt + 64'd21);

        // R8: phase wait times out with no answer
        send(2'd0, 64'd0, dummy);
        send(2'd1, 64'd50, dummy);
        send(2'd2, 64'd0, dummy);
        wait_sig(0, seen, lt);
        @(negedge clk);
        send(2'd3, 64'd60, dummy);
        wait_sig(2, seen, lt);
        chk("R8 phase wait expired", 64'(seen), 64'd0);

        // Block is back in idle and completes a fresh exchange
        run_vec(64'd2000000, 64'd2000040, 64'd6, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule